// File: doc/BRIEF.md
# Multimode Counter and Shift Register

A small register slice, four bits wide by default, whose behaviour on each rising clock edge is chosen by a 3-bit mode select. The modes are the states of the block:

- LOAD takes the preset word.
- INVERT flips every bit.
- SHR moves the word one place toward the LSB, with a separate serial input entering at the MSB.
- SHL moves the word one place toward the MSB, with the combined enable/serial input entering at the LSB.
- DOWN decrements modulo 2^WIDTH.
- CLEAR zeroes the word on the edge.
- UP increments modulo 2^WIDTH.
- HOLD keeps the word.

The transition from one mode to another happens whenever the select changes. It takes effect at the next edge, and no extra cycle is spent. A high asynchronous master reset zeroes the register at once and overrides every mode.

Two active-low enables gate counting. The trickle enable doubles as the shift-toward-MSB serial input. The active-low terminal-count output doubles as a copy of the MSB while shifting. Because of this pairing, one wire from the terminal-count output of a stage to the enable/serial input of the next stage chains several slices into a wider counter or a wider shift-toward-MSB register. True and complemented data outputs are both provided.

Top module: `mode_shift_counter`

## Requirements
- R1: While `arst` is high, `q` is 0 at once, with no clock edge needed, whatever the mode and the other inputs are.
- R2: Mode 3'b000 (LOAD) loads `preset` into `q` on the rising edge.
- R3: Mode 3'b001 (INVERT) replaces `q` with its bitwise inverse on the rising edge.
- R4: Mode 3'b010 (SHR) makes the next `q` equal to {`ser_lsb_in`, q[WIDTH-1:1]}.
- R5: Mode 3'b011 (SHL) makes the next `q` equal to {q[WIDTH-2:0], `cet_ser_n`}.
- R6: Mode 3'b100 (DOWN) decrements `q` modulo 2^WIDTH when `cnt_en_n` and `cet_ser_n` are both low.
- R7: Mode 3'b110 (UP) increments `q` modulo 2^WIDTH when `cnt_en_n` and `cet_ser_n` are both low.
- R8: In DOWN or UP, `q` keeps its value if `cnt_en_n` or `cet_ser_n` is high.
- R9: Mode 3'b101 (CLEAR) makes `q` 0 on the edge, and mode 3'b111 (HOLD) keeps `q` unchanged.
- R10: In UP, `tc_n` is low exactly when `cet_ser_n` is low and `q` is all ones. In DOWN, `tc_n` is low exactly when `cet_ser_n` is low and `q` is 0. Otherwise `tc_n` is high in both count modes.
- R11: `tc_n` follows the mode and the current `q` combinationally. It equals q[WIDTH-1] in SHR and SHL, is low in LOAD and INVERT, and is high in CLEAR and HOLD.
- R12: `q_n` is always the bitwise inverse of `q`.
- R13: Two slices chained by wiring the lower `tc_n` to the upper `cet_ser_n` count up and down as one 2*WIDTH-bit counter. The same pair shifts toward the MSB as one 2*WIDTH-bit register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| arst | input | 1 | Asynchronous active-high master reset |
| mode_sel | input | 3 | Mode select, encoded as in R2 to R9 |
| cnt_en_n | input | 1 | Active-low parallel count enable |
| cet_ser_n | input | 1 | Active-low trickle count enable, also the serial input for SHL |
| ser_lsb_in | input | 1 | Serial input for SHR, entering at the MSB |
| preset | input | WIDTH | Parallel load word |
| q | output | WIDTH | Register contents |
| q_n | output | WIDTH | Bitwise complement of q |
| tc_n | output | 1 | Active-low terminal count, or the MSB while shifting |

## Verification
A wrong register value appears on `q` and `q_n` right after the edge that stores it. In the count and shift modes it also appears on `tc_n` during the same cycle, because that output is decoded from the present word. In a chain, the upper slice picks up the error one edge later, as a count step that is missing or extra, or as a wrong shifted-in bit. The bench therefore sweeps every mode against every starting word and every enable and serial combination. It checks the outputs before the edge and after it, then runs long cascaded count and shift sequences on a chained pair.

// File: rtl/msc_pkg.sv
package msc_pkg;

    typedef enum logic [2:0] {
        MODE_LOAD   = 3'b000,
        MODE_INVERT = 3'b001,
        MODE_SHR    = 3'b010,
        MODE_SHL    = 3'b011,
        MODE_DOWN   = 3'b100,
        MODE_CLEAR  = 3'b101,
        MODE_UP     = 3'b110,
        MODE_HOLD   = 3'b111
    } msc_mode_e;

endpackage

// File: rtl/msc_next_state.sv
module msc_next_state
    import msc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  msc_mode_e        mode,
    input  logic             cnt_en_n,
    input  logic             cet_ser_n,
    input  logic             ser_lsb_in,
    input  logic [WIDTH-1:0] preset,
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    logic count_ok;

    assign count_ok = !cnt_en_n && !cet_ser_n;

    always_comb begin
        nxt = cur;
        unique case (mode)
            MODE_LOAD:   nxt = preset;
            MODE_INVERT: nxt = ~cur;
            MODE_SHR:    nxt = {ser_lsb_in, cur[WIDTH-1:1]};
            MODE_SHL:    nxt = {cur[WIDTH-2:0], cet_ser_n};
            MODE_DOWN:   nxt = count_ok ? cur - STEP : cur;
            MODE_CLEAR:  nxt = '0;
            MODE_UP:     nxt = count_ok ? cur + STEP : cur;
            MODE_HOLD:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/msc_term_count.sv
module msc_term_count
    import msc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  msc_mode_e        mode,
    input  logic             cet_ser_n,
    input  logic [WIDTH-1:0] cur,
    output logic             tc_n
);

    logic at_top;
    logic at_bottom;

    assign at_top    = &cur;
    assign at_bottom = ~|cur;

    always_comb begin
        tc_n = 1'b1;
        unique case (mode)
            MODE_LOAD:   tc_n = 1'b0;
            MODE_INVERT: tc_n = 1'b0;
            MODE_SHR:    tc_n = cur[WIDTH-1];
            MODE_SHL:    tc_n = cur[WIDTH-1];
            MODE_DOWN:   tc_n = !(at_bottom && !cet_ser_n);
            MODE_CLEAR:  tc_n = 1'b1;
            MODE_UP:     tc_n = !(at_top && !cet_ser_n);
            MODE_HOLD:   tc_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/msc_state_reg.sv
module msc_state_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             arst,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] cur
);

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/mode_shift_counter.sv
module mode_shift_counter
    import msc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             arst,
    input  logic [2:0]       mode_sel,
    input  logic             cnt_en_n,
    input  logic             cet_ser_n,
    input  logic             ser_lsb_in,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] q_n,
    output logic             tc_n
);

    msc_mode_e        mode;
    logic [WIDTH-1:0] cur;
    logic [WIDTH-1:0] nxt;

    assign mode = msc_mode_e'(mode_sel);

    msc_next_state #(.WIDTH(WIDTH)) u_next (
        .mode       (mode),
        .cnt_en_n   (cnt_en_n),
        .cet_ser_n  (cet_ser_n),
        .ser_lsb_in (ser_lsb_in),
        .preset     (preset),
        .cur        (cur),
        .nxt        (nxt)
    );

    msc_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk  (clk),
        .arst (arst),
        .nxt  (nxt),
        .cur  (cur)
    );

    msc_term_count #(.WIDTH(WIDTH)) u_tc (
        .mode      (mode),
        .cet_ser_n (cet_ser_n),
        .cur       (cur),
        .tc_n      (tc_n)
    );

    assign q   = cur;
    assign q_n = ~cur;

endmodule

// File: rtl/msc_checker.sv
module msc_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             arst,
    input logic [2:0]       mode_sel,
    input logic             cnt_en_n,
    input logic             cet_ser_n,
    input logic             ser_lsb_in,
    input logic [WIDTH-1:0] preset,
    input logic [WIDTH-1:0] q,
    input logic [WIDTH-1:0] q_n,
    input logic             tc_n
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    AST_LOAD_TAKES_PRESET: assert property (@(posedge clk) disable iff (arst)
        mode_sel == 3'b000 |=> q == $past(preset)); // R2

    AST_INVERT_FLIPS: assert property (@(posedge clk) disable iff (arst)
        mode_sel == 3'b001 |=> q == ~$past(q)); // R3

    AST_SHR_MOVES: assert property (@(posedge clk) disable iff (arst)
        mode_sel == 3'b010 |=> q == {$past(ser_lsb_in), $past(q[WIDTH-1:1])}); // R4

    AST_SHL_MOVES: assert property (@(posedge clk) disable iff (arst)
        mode_sel == 3'b011 |=> q == {$past(q[WIDTH-2:0]), $past(cet_ser_n)}); // R5

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (arst)
        (mode_sel == 3'b100 && !cnt_en_n && !cet_ser_n) |=> q == $past(q) - ONE); // R6

    AST_UP_STEP: assert property (@(posedge clk) disable iff (arst)
        (mode_sel == 3'b110 && !cnt_en_n && !cet_ser_n) |=> q == $past(q) + ONE); // R7

    AST_COUNT_GATED: assert property (@(posedge clk) disable iff (arst)
        (mode_sel[2] && !mode_sel[0] && (cnt_en_n || cet_ser_n)) |=> $stable(q)); // R8

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (arst)
        mode_sel == 3'b101 |=> q == '0); // R9

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (arst)
        mode_sel == 3'b111 |=> $stable(q)); // R9

    AST_TC_IDLE_HIGH: assert property (@(posedge clk) disable iff (arst)
        (mode_sel[2] && !mode_sel[0] && cet_ser_n) |-> tc_n); // R10

    AST_TC_SHIFT_MSB: assert property (@(posedge clk) disable iff (arst)
        (mode_sel[2:1] == 2'b01) |-> tc_n == q[WIDTH-1]); // R11

    AST_QN_INVERSE: assert property (@(posedge clk) disable iff (arst)
        1'b1 |-> (q ^ q_n) == {WIDTH{1'b1}}); // R12

endmodule

bind mode_shift_counter msc_checker #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .arst       (arst),
    .mode_sel   (mode_sel),
    .cnt_en_n   (cnt_en_n),
    .cet_ser_n  (cet_ser_n),
    .ser_lsb_in (ser_lsb_in),
    .preset     (preset),
    .q          (q),
    .q_n        (q_n),
    .tc_n       (tc_n)
);

// File: tb/mode_shift_counter_tb.sv
module mode_shift_counter_tb;

    logic       clk = 1'b0;
    logic       arst = 1'b1;
    logic [2:0] lo_mode = 3'b111;
    logic [2:0] hi_mode = 3'b111;
    logic       lo_cep_n = 1'b1;
    logic       hi_cep_n = 1'b1;
    logic       lo_cet_n = 1'b1;
    logic       lo_d3 = 1'b0;
    logic [3:0] lo_preset = 4'd0;
    logic [3:0] lo_q, lo_qn, hi_q, hi_qn;
    logic       lo_tc_n, hi_tc_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mode_shift_counter #(.WIDTH(4)) u_dut (
        .clk(clk), .arst(arst), .mode_sel(lo_mode), .cnt_en_n(lo_cep_n),
        .cet_ser_n(lo_cet_n), .ser_lsb_in(lo_d3), .preset(lo_preset),
        .q(lo_q), .q_n(lo_qn), .tc_n(lo_tc_n)
    );

    mode_shift_counter #(.WIDTH(4)) u_dut_hi (
        .clk(clk), .arst(arst), .mode_sel(hi_mode), .cnt_en_n(hi_cep_n),
        .cet_ser_n(lo_tc_n), .ser_lsb_in(1'b0), .preset(4'd0),
        .q(hi_q), .q_n(hi_qn), .tc_n(hi_tc_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string req_of(input int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6/R8";
            6: return "R7/R8";
            default: return "R9";
        endcase
    endfunction

    function automatic int exp_next(input int m, input int s, input int cep,
                                    input int cet, input int d3, input int p);
        case (m)
            0: return p;
            1: return 15 - s;
            2: return d3 * 8 + s / 2;
            3: return (s * 2) % 16 + cet;
            4: return (cep == 0 && cet == 0) ? (s + 15) % 16 : s;
            5: return 0;
            6: return (cep == 0 && cet == 0) ? (s + 1) % 16 : s;
            default: return s;
        endcase
    endfunction

    function automatic int exp_tc(input int m, input int s, input int cet);
        case (m)
            0, 1: return 0;
            2, 3: return s / 8;
            4: return (cet == 0 && s == 0) ? 0 : 1;
            6: return (cet == 0 && s == 15) ? 0 : 1;
            default: return 1;
        endcase
    endfunction

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ref8;
        // R1: reset state
        #12;
        chk("R1 reset q", lo_q, 0);
        chk("R12 reset q_n", lo_qn, 15);
        chk("R11 reset tc_n hold", lo_tc_n, 1);
        @(negedge clk);
        arst = 1'b0;

        // R1: asynchronous clear mid-run, overriding load
        lo_mode = 3'b000;
        lo_preset = 4'd9;
        @(negedge clk);
        chk("R2 load 9", lo_q, 9);
        #3 arst = 1'b1;
        #1 chk("R1 async clear", lo_q, 0);
        @(negedge clk);
        chk("R1 overrides load", lo_q, 0);
        arst = 1'b0;
        @(negedge clk);
        chk("R2 load after reset", lo_q, 9);

        // exhaustive sweep: mode x start word x cep x cet x d3
        for (int m = 0; m < 8; m++) begin
            for (int s = 0; s < 16; s++) begin
                for (int c = 0; c < 8; c++) begin
                    int cep = c % 2;
                    int cet = (c / 2) % 2;
                    int d3 = c / 4;
                    int p = (s * 7 + m + 3) % 16;
                    lo_mode = 3'b000;
                    lo_preset = 4'(s);
                    @(negedge clk);
                    lo_mode = 3'(m);
                    lo_cep_n = cep[0];
                    lo_cet_n = cet[0];
                    lo_d3 = d3[0];
                    lo_preset = 4'(p);
                    #1;
                    chk((m == 4 || m == 6) ? "R10 tc_n" : "R11 tc_n",
                        lo_tc_n, exp_tc(m, s, cet));
                    chk("R12 q_n", lo_qn, 15 - s);
                    @(negedge clk);
                    chk(req_of(m), lo_q, exp_next(m, s, cep, cet, d3, p));
                end
            end
        end

        // R13: cascaded 8-bit count up
        arst = 1'b1;
        @(negedge clk);
        arst = 1'b0;
        lo_mode = 3'b110; hi_mode = 3'b110;
        lo_cep_n = 1'b0; hi_cep_n = 1'b0; lo_cet_n = 1'b0;
        for (int k = 1; k <= 300; k++) begin
            @(negedge clk);
            chk("R13 cascade up", {hi_q, lo_q}, k % 256);
            if (k % 256 == 255) chk("R13 cascade top tc_n", hi_tc_n, 0);
        end

        // R13: cascaded 8-bit count down
        arst = 1'b1;
        @(negedge clk);
        arst = 1'b0;
        lo_mode = 3'b100; hi_mode = 3'b100;
        for (int k = 1; k <= 300; k++) begin
            @(negedge clk);
            chk("R13 cascade down", {hi_q, lo_q}, (256 - (k % 256)) % 256);
        end

        // R13: cascaded 8-bit shift toward MSB
        arst = 1'b1;
        @(negedge clk);
        arst = 1'b0;
        lo_mode = 3'b011; hi_mode = 3'b011;
        ref8 = 0;
        for (int k = 0; k < 64; k++) begin
            int b = ((k * k + k / 3) >> 1) % 2;
            lo_cet_n = b[0];
            @(negedge clk);
            ref8 = (ref8 * 2 + b) % 256;
            chk("R13 cascade shift", {hi_q, lo_q}, ref8);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule